// File: doc/BRIEF.md
# Segmented and Paged Address Translator

This block turns a logical address into a physical address. A logical address is a 16-bit selector plus a 32-bit offset. The first pipeline stage works out the segment. In real mode the selector, shifted left by four bits, is added to the offset and the sum is cut to 20 bits. In protected mode, selector bits [15:3] pick an entry from a 16-entry segment table. That entry's base is added to the offset, and the offset is checked against the entry's limit and its write permission.

The second stage sits beneath the first. When paging is switched on in protected mode, the upper 20 bits of the linear address are looked up in an 8-slot fully associative page map. The 12-bit byte offset passes through unchanged.

Requests and responses each use a valid/ready handshake. An unstalled request answers exactly two clock edges after it is accepted. Each response carries exactly one status: address OK, segment fault, protection fault or page miss. Software-side code fills the two tables through their own write ports.

Top module: `addr_xlate`

## Requirements
- R1: With `req_prot` low, the physical address is ((selector << 4) + offset) mod 2^20 and the status is OK. `req_paging`, `req_write` and the table contents have no effect.
- R2: In protected mode with paging off, the physical address is (entry base + offset) mod 2^32.
- R3: The entry index is selector bits [15:3], and bits [2:0] are ignored. An index of 16 or more, or an entry whose present flag is clear, gives a segment fault.
- R4: An offset strictly greater than the entry limit gives a protection fault. An offset equal to the limit is allowed.
- R5: A write (`req_write`=1) to an entry marked read-only gives a protection fault. A read of the same entry succeeds.
- R6: In protected mode with paging on, a linear page number held in a valid slot gives the physical address {slot frame, linear[11:0]}.
- R7: A page number with no matching valid slot gives a page miss, and invalid slots never match. When several valid slots match, the lowest-numbered slot wins.
- R8: Every response raises exactly one of `rsp_ok`, `rsp_seg_fault`, `rsp_prot_fault` and `rsp_page_miss`. On any fault `rsp_paddr` is zero. Fault priority runs segment, then protection, then page miss, so a segment-stage fault is never replaced by a page miss.
- R9: A request accepted at a clock edge appears on the response port after the second edge. While `rsp_valid` is high and `rsp_ready` is low, the response holds steady and `req_ready` is low.
- R10: After reset, `rsp_valid` is low, `req_ready` is high, and both tables are empty. A protected-mode request then gives a segment fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this edge |
| req_sel | input | 16 | Selector |
| req_off | input | 32 | Offset |
| req_write | input | 1 | Access is a write |
| req_prot | input | 1 | Protected mode (0 = real mode) |
| req_paging | input | 1 | Paging enable (protected mode only) |
| dwr_en | input | 1 | Segment table write strobe |
| dwr_idx | input | 4 | Segment table entry written |
| dwr_base | input | 32 | Entry base |
| dwr_limit | input | 32 | Entry limit (highest legal offset) |
| dwr_ro | input | 1 | Entry is read-only |
| dwr_present | input | 1 | Entry present |
| pwr_en | input | 1 | Page map write strobe |
| pwr_slot | input | 3 | Page slot written |
| pwr_lpn | input | 20 | Linear page number |
| pwr_pfn | input | 20 | Frame number |
| pwr_valid | input | 1 | Slot valid |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes response |
| rsp_paddr | output | 32 | Physical address (zero on fault) |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_seg_fault | output | 1 | Missing or absent segment entry |
| rsp_prot_fault | output | 1 | Limit or write-permission violation |
| rsp_page_miss | output | 1 | No valid page slot matched |

## Verification
The bench targets these corner cases:
- An offset exactly at the limit and one step past it. An off-by-one compare would fault on the legal access or let the illegal one through.
- Selector index 16, which lies just outside the table. A design that used only the low index bits would alias it onto entry 0.
- A base-plus-offset that wraps past 2^32, and a real-mode sum that wraps past 2^20. A design that kept carry bits would emit an address outside the range.
- Duplicate and invalid page slots. A design that lets the highest slot win, or matches slots regardless of their valid flag, would return the wrong frame or a false hit.
- A back-pressured response. A design that kept advancing under stall would lose or overwrite the held response.

// File: rtl/xlate_pkg.sv
`timescale 1ns/1ps
package xlate_pkg;

  typedef enum logic [1:0] {
    ST_OK   = 2'd0,
    ST_SEG  = 2'd1,
    ST_PROT = 2'd2,
    ST_MISS = 2'd3
  } xl_status_e;

  typedef struct packed {
    logic [31:0] base;
    logic [31:0] limit;
    logic        ro;
    logic        present;
  } seg_desc_t;

  typedef struct packed {
    logic [19:0] lpn;
    logic [19:0] pfn;
    logic        valid;
  } page_ent_t;

endpackage

// File: rtl/xl_seg_unit.sv
`timescale 1ns/1ps
module xl_seg_unit
  import xlate_pkg::*;
#(
  parameter int N_DESC = 16,
  localparam int IDXW  = $clog2(N_DESC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             in_valid,
  input  logic [15:0]      in_sel,
  input  logic [31:0]      in_off,
  input  logic             in_write,
  input  logic             in_prot,
  input  logic             in_paging,
  input  logic             dwr_en,
  input  logic [IDXW-1:0]  dwr_idx,
  input  seg_desc_t        dwr_data,
  output logic             s1_valid,
  output logic [31:0]      s1_lin,
  output xl_status_e       s1_status,
  output logic             s1_pg
);

  localparam int SELIDXW = 13;

  seg_desc_t  desc_q [N_DESC];
  seg_desc_t  desc_d [N_DESC];

  logic [SELIDXW-1:0] idx_full;
  logic               in_range;
  seg_desc_t          ent;
  logic [31:0]        lin_d;
  xl_status_e         st_d;
  logic               pg_d;

  logic               s1_valid_q, s1_pg_q, s1_prot_q;
  logic [31:0]        s1_lin_q;
  xl_status_e         s1_status_q;

  // table next state
  always_comb begin
    for (int i = 0; i < N_DESC; i++) desc_d[i] = desc_q[i];
    if (dwr_en) desc_d[dwr_idx] = dwr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_DESC; i++) desc_q[i] <= '0;
    end else if (dwr_en) begin
      for (int i = 0; i < N_DESC; i++) desc_q[i] <= desc_d[i];
    end
  end

  // segmentation: real-mode shift-add or table lookup with checks
  always_comb begin
    idx_full = in_sel[15:3];
    in_range = (idx_full < SELIDXW'(N_DESC));
    ent      = desc_q[idx_full[IDXW-1:0]];
    lin_d    = '0;
    st_d     = ST_OK;
    pg_d     = 1'b0;
    if (!in_prot) begin
      lin_d = (({16'b0, in_sel} << 4) + in_off) & 32'h000F_FFFF;
    end else if (!in_range || !ent.present) begin
      st_d = ST_SEG;
    end else if ((in_off > ent.limit) || (in_write && ent.ro)) begin
      st_d = ST_PROT;
    end else begin
      lin_d = ent.base + in_off;
      pg_d  = in_paging;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q  <= 1'b0;
      s1_lin_q    <= '0;
      s1_status_q <= ST_OK;
      s1_pg_q     <= 1'b0;
      s1_prot_q   <= 1'b0;
    end else if (adv) begin
      s1_valid_q  <= in_valid;
      s1_lin_q    <= lin_d;
      s1_status_q <= st_d;
      s1_pg_q     <= pg_d;
      s1_prot_q   <= in_prot;
    end
  end

  assign s1_valid  = s1_valid_q;
  assign s1_lin    = s1_lin_q;
  assign s1_status = s1_status_q;
  assign s1_pg     = s1_pg_q;

  // R1: real mode stays inside 1 MB, never faults, never pages
  a_r1_real_20bit: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid_q && !s1_prot_q) |-> (s1_lin_q[31:20] == 12'h0 && s1_status_q == ST_OK && !s1_pg_q));

  // R3: segment faults only arise from protected-mode lookups
  a_r3_segf_prot: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid_q && s1_status_q == ST_SEG) |-> s1_prot_q);

endmodule

// File: rtl/xl_page_unit.sv
`timescale 1ns/1ps
module xl_page_unit
  import xlate_pkg::*;
#(
  parameter int N_PAGE = 8,
  localparam int SLOTW = $clog2(N_PAGE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             s1_valid,
  input  logic [31:0]      s1_lin,
  input  xl_status_e       s1_status,
  input  logic             s1_pg,
  input  logic             pwr_en,
  input  logic [SLOTW-1:0] pwr_slot,
  input  page_ent_t        pwr_data,
  output logic             out_valid,
  output logic [31:0]      out_paddr,
  output xl_status_e       out_status
);

  page_ent_t  pg_q [N_PAGE];
  page_ent_t  pg_d [N_PAGE];

  logic [N_PAGE-1:0] match;
  logic              hit;
  logic [19:0]       pfn_sel;
  logic [31:0]       paddr_d;
  xl_status_e        st_d;

  logic              out_valid_q, out_pg_q;
  logic [31:0]       out_paddr_q;
  xl_status_e        out_status_q;

  always_comb begin
    for (int i = 0; i < N_PAGE; i++) pg_d[i] = pg_q[i];
    if (pwr_en) pg_d[pwr_slot] = pwr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_PAGE; i++) pg_q[i] <= '0;
    end else if (pwr_en) begin
      for (int i = 0; i < N_PAGE; i++) pg_q[i] <= pg_d[i];
    end
  end

  // associative compare, one comparator per slot
  for (genvar g = 0; g < N_PAGE; g++) begin : g_cmp
    assign match[g] = pg_q[g].valid && (pg_q[g].lpn == s1_lin[31:12]);
  end

  // lowest slot wins: scan from the top so lower indices overwrite
  always_comb begin
    pfn_sel = '0;
    for (int i = N_PAGE - 1; i >= 0; i--) begin
      if (match[i]) pfn_sel = pg_q[i].pfn;
    end
    hit = |match;
  end

  always_comb begin
    paddr_d = '0;
    st_d    = s1_status;
    if (s1_status == ST_OK) begin
      if (!s1_pg) begin
        paddr_d = s1_lin;
      end else if (hit) begin
        paddr_d = {pfn_sel, s1_lin[11:0]};
      end else begin
        st_d = ST_MISS;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q  <= 1'b0;
      out_paddr_q  <= '0;
      out_status_q <= ST_OK;
      out_pg_q     <= 1'b0;
    end else if (adv) begin
      out_valid_q  <= s1_valid;
      out_paddr_q  <= paddr_d;
      out_status_q <= st_d;
      out_pg_q     <= s1_pg;
    end
  end

  assign out_valid  = out_valid_q;
  assign out_paddr  = out_paddr_q;
  assign out_status = out_status_q;

  // R8: faulting responses carry a zero address
  a_r8_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_q && out_status_q != ST_OK) |-> (out_paddr_q == 32'h0));

  // R7: a page miss only comes from a request that went through paging
  a_r7_miss_paged: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_q && out_status_q == ST_MISS) |-> out_pg_q);

endmodule

// File: rtl/addr_xlate.sv
`timescale 1ns/1ps
module addr_xlate
  import xlate_pkg::*;
#(
  parameter int N_DESC = 16,
  parameter int N_PAGE = 8,
  localparam int IDXW  = $clog2(N_DESC),
  localparam int SLOTW = $clog2(N_PAGE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [15:0]      req_sel,
  input  logic [31:0]      req_off,
  input  logic             req_write,
  input  logic             req_prot,
  input  logic             req_paging,
  input  logic             dwr_en,
  input  logic [IDXW-1:0]  dwr_idx,
  input  logic [31:0]      dwr_base,
  input  logic [31:0]      dwr_limit,
  input  logic             dwr_ro,
  input  logic             dwr_present,
  input  logic             pwr_en,
  input  logic [SLOTW-1:0] pwr_slot,
  input  logic [19:0]      pwr_lpn,
  input  logic [19:0]      pwr_pfn,
  input  logic             pwr_valid,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [31:0]      rsp_paddr,
  output logic             rsp_ok,
  output logic             rsp_seg_fault,
  output logic             rsp_prot_fault,
  output logic             rsp_page_miss
);

  logic [1:0]  rst_sync_q;
  logic        rst_n_i;
  logic        adv;
  logic        s1_valid, s1_pg;
  logic [31:0] s1_lin;
  xl_status_e  s1_status;
  xl_status_e  out_status;
  seg_desc_t   dwr_data;
  page_ent_t   pwr_data;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  // whole pipe advances unless a response is held
  assign adv       = !rsp_valid || rsp_ready;
  assign req_ready = adv;

  assign dwr_data = '{base: dwr_base, limit: dwr_limit, ro: dwr_ro, present: dwr_present};
  assign pwr_data = '{lpn: pwr_lpn, pfn: pwr_pfn, valid: pwr_valid};

  xl_seg_unit #(.N_DESC(N_DESC)) i_seg (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .adv       (adv),
    .in_valid  (req_valid),
    .in_sel    (req_sel),
    .in_off    (req_off),
    .in_write  (req_write),
    .in_prot   (req_prot),
    .in_paging (req_paging),
    .dwr_en    (dwr_en),
    .dwr_idx   (dwr_idx),
    .dwr_data  (dwr_data),
    .s1_valid  (s1_valid),
    .s1_lin    (s1_lin),
    .s1_status (s1_status),
    .s1_pg     (s1_pg)
  );

  xl_page_unit #(.N_PAGE(N_PAGE)) i_page (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .adv        (adv),
    .s1_valid   (s1_valid),
    .s1_lin     (s1_lin),
    .s1_status  (s1_status),
    .s1_pg      (s1_pg),
    .pwr_en     (pwr_en),
    .pwr_slot   (pwr_slot),
    .pwr_data   (pwr_data),
    .out_valid  (rsp_valid),
    .out_paddr  (rsp_paddr),
    .out_status (out_status)
  );

  always_comb begin
    rsp_ok         = rsp_valid && (out_status == ST_OK);
    rsp_seg_fault  = rsp_valid && (out_status == ST_SEG);
    rsp_prot_fault = rsp_valid && (out_status == ST_PROT);
    rsp_page_miss  = rsp_valid && (out_status == ST_MISS);
  end

  // R8: exactly one status per response
  a_r8_one_status: assert property (@(posedge clk) disable iff (!rst_n_i)
    rsp_valid |-> ($countones({rsp_ok, rsp_seg_fault, rsp_prot_fault, rsp_page_miss}) == 1));

  // R9: a stalled response stays put
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n_i)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(out_status)));

endmodule

// File: tb/test_addr_xlate.sv
`timescale 1ns/1ps
module test_addr_xlate;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write, req_prot, req_paging;
  logic [15:0] req_sel;
  logic [31:0] req_off;
  logic        dwr_en, dwr_ro, dwr_present;
  logic [3:0]  dwr_idx;
  logic [31:0] dwr_base, dwr_limit;
  logic        pwr_en, pwr_valid;
  logic [2:0]  pwr_slot;
  logic [19:0] pwr_lpn, pwr_pfn;
  logic        rsp_valid, rsp_ready;
  logic [31:0] rsp_paddr;
  logic        rsp_ok, rsp_seg_fault, rsp_prot_fault, rsp_page_miss;

  always #5 clk = ~clk;

  addr_xlate i_addr_xlate (.*);

  // status nibble {ok, seg, prot, miss}
  localparam logic [3:0] S_OK = 4'b1000, S_SEG = 4'b0100, S_PROT = 4'b0010, S_MISS = 4'b0001;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [31:0] sd_base [16];
  logic [31:0] sd_lim  [16];
  logic        sd_ro   [16];
  logic        sd_pr   [16];
  logic [19:0] sp_lpn  [8];
  logic [19:0] sp_pfn  [8];
  logic        sp_v    [8];

  logic [3:0]  q_st  [$];
  logic [31:0] q_a   [$];
  int          q_c   [$];
  bit          q_lat [$];
  string       q_tag [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic model(input logic [15:0] sel, input logic [31:0] off, input logic wr,
                       input logic prot, input logic pg,
                       output logic [3:0] st, output logic [31:0] a);
    int idx;
    logic [31:0] lin;
    idx = int'(sel[15:3]);
    st = S_OK; a = 32'h0;
    if (!prot) begin
      a = ({16'h0, sel} * 32'd16 + off) % 32'h0010_0000;
    end else if (idx > 15 || !sd_pr[idx]) begin
      st = S_SEG;
    end else if (off > sd_lim[idx] || (wr && sd_ro[idx])) begin
      st = S_PROT;
    end else begin
      lin = sd_base[idx] + off;
      if (!pg) a = lin;
      else begin
        st = S_MISS;
        for (int i = 7; i >= 0; i--)
          if (sp_v[i] && sp_lpn[i] == lin[31:12]) begin st = S_OK; a = {sp_pfn[i], lin[11:0]}; end
      end
    end
  endtask

  task automatic send(input logic [15:0] sel, input logic [31:0] off, input logic wr,
                      input logic prot, input logic pg, input bit lat, input string tag);
    logic [3:0] st; logic [31:0] a;
    model(sel, off, wr, prot, pg, st, a);
    req_valid = 1'b1; req_sel = sel; req_off = off; req_write = wr;
    req_prot = prot; req_paging = pg;
    while (!req_ready) @(negedge clk);
    q_st.push_back(st); q_a.push_back(a); q_c.push_back(cyc);
    q_lat.push_back(lat); q_tag.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr_desc(input int idx, input logic [31:0] base, input logic [31:0] lim,
                         input logic ro, input logic pr);
    dwr_en = 1'b1; dwr_idx = 4'(idx); dwr_base = base; dwr_limit = lim;
    dwr_ro = ro; dwr_present = pr;
    sd_base[idx] = base; sd_lim[idx] = lim; sd_ro[idx] = ro; sd_pr[idx] = pr;
    @(negedge clk);
    dwr_en = 1'b0;
  endtask

  task automatic wr_page(input int slot, input logic [19:0] lpn, input logic [19:0] pfn,
                         input logic v);
    pwr_en = 1'b1; pwr_slot = 3'(slot); pwr_lpn = lpn; pwr_pfn = pfn; pwr_valid = v;
    sp_lpn[slot] = lpn; sp_pfn[slot] = pfn; sp_v[slot] = v;
    @(negedge clk);
    pwr_en = 1'b0;
  endtask

  task automatic set_rdy(input logic v);
    @(posedge clk); #2;
    rsp_ready = v;
    @(negedge clk);
  endtask

  // monitor: pop and compare every accepted response
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      logic [3:0] got;
      got = {rsp_ok, rsp_seg_fault, rsp_prot_fault, rsp_page_miss};
      checks++;
      if (q_st.size() == 0) begin
        fails++;
        $display("FAIL R9 unexpected response: got st=%b addr=%h expected none", got, rsp_paddr);
      end else begin
        logic [3:0] est; logic [31:0] ea; int ec; bit el; string et;
        est = q_st.pop_front(); ea = q_a.pop_front(); ec = q_c.pop_front();
        el = q_lat.pop_front(); et = q_tag.pop_front();
        if (got !== est || rsp_paddr !== ea) begin
          fails++;
          $display("FAIL %s: got st=%b addr=%h expected st=%b addr=%h", et, got, rsp_paddr, est, ea);
        end
        if (el && cyc != ec + 2) begin
          fails++;
          $display("FAIL R9 latency (%s): got cycle %0d expected %0d", et, cyc, ec + 2);
        end
      end
    end
  end

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [3:0] est; logic [31:0] ea;
    rst_n = 1'b0; req_valid = 1'b0; req_sel = '0; req_off = '0; req_write = 1'b0;
    req_prot = 1'b0; req_paging = 1'b0; rsp_ready = 1'b1;
    dwr_en = 1'b0; dwr_idx = '0; dwr_base = '0; dwr_limit = '0; dwr_ro = 1'b0; dwr_present = 1'b0;
    pwr_en = 1'b0; pwr_slot = '0; pwr_lpn = '0; pwr_pfn = '0; pwr_valid = 1'b0;
    for (int i = 0; i < 16; i++) begin sd_base[i] = '0; sd_lim[i] = '0; sd_ro[i] = 1'b0; sd_pr[i] = 1'b0; end
    for (int i = 0; i < 8; i++) begin sp_lpn[i] = '0; sp_pfn[i] = '0; sp_v[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset state
    checks++;
    if (rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
      fails++;
      $display("FAIL R10 reset: got valid=%b ready=%b expected valid=0 ready=1", rsp_valid, req_ready);
    end
    send(16'h0008, 32'h10, 1'b0, 1'b1, 1'b0, 1, "R10 empty table segfault");

    // R1: real mode, wrap at 1 MB, paging and write ignored
    send(16'hF000, 32'h000F_FFF0, 1'b1, 1'b0, 1'b1, 1, "R1 real wrap");
    send(16'h1234, 32'h0000_0005, 1'b0, 1'b0, 1'b0, 1, "R1 real plain");

    wr_desc(0, 32'h1000_0000, 32'h0000_FFFF, 1'b0, 1'b1);
    wr_desc(1, 32'hFFFF_F000, 32'hFFFF_FFFF, 1'b1, 1'b1);
    wr_desc(5, 32'h2000_0000, 32'hFFFF_FFFF, 1'b0, 1'b0);
    wr_desc(15, 32'h0ABC_0000, 32'h0000_0100, 1'b0, 1'b1);

    // R2 / R3: low selector bits ignored, 32-bit wrap
    send(16'h0007, 32'h0000_1234, 1'b0, 1'b1, 1'b0, 1, "R2 R3 base+off");
    send(16'h0008, 32'h0000_2000, 1'b0, 1'b1, 1'b0, 1, "R2 wrap 2^32");
    send(16'h0078, 32'h0000_0100, 1'b0, 1'b1, 1'b0, 1, "R2 last entry");
    // R3: absent entry and index 16
    send(16'h0028, 32'h0, 1'b0, 1'b1, 1'b0, 1, "R3 not present");
    send(16'h0080, 32'h0, 1'b0, 1'b1, 1'b0, 1, "R3 index 16");
    // R4: limit edge
    send(16'h0000, 32'h0000_FFFF, 1'b0, 1'b1, 1'b0, 1, "R4 at limit");
    send(16'h0000, 32'h0001_0000, 1'b0, 1'b1, 1'b0, 1, "R4 past limit");
    // R5: read-only
    send(16'h0008, 32'h10, 1'b1, 1'b1, 1'b0, 1, "R5 write read-only");
    send(16'h0000, 32'h10, 1'b1, 1'b1, 1'b0, 1, "R5 write writable");

    wr_page(2, 20'h10001, 20'hABCDE, 1'b1);
    wr_page(5, 20'h10001, 20'h11111, 1'b1);
    wr_page(3, 20'h10002, 20'h22222, 1'b0);
    wr_page(7, 20'h0ABC0, 20'h55555, 1'b1);

    // R6 / R7
    send(16'h0000, 32'h0000_1234, 1'b0, 1'b1, 1'b1, 1, "R6 R7 hit lowest slot");
    send(16'h0078, 32'h0000_00FF, 1'b0, 1'b1, 1'b1, 1, "R6 hit slot 7");
    send(16'h0000, 32'h0000_2345, 1'b0, 1'b1, 1'b1, 1, "R7 invalid slot miss");
    send(16'h0000, 32'h0000_3000, 1'b0, 1'b1, 1'b1, 1, "R7 no slot miss");
    // R8: segment-stage faults take priority over paging
    send(16'h0000, 32'h0002_0000, 1'b0, 1'b1, 1'b1, 1, "R8 prot before miss");
    send(16'h0028, 32'h0, 1'b0, 1'b1, 1'b1, 1, "R8 seg before miss");
    send(16'h0001, 32'h0000_1000, 1'b0, 1'b0, 1'b1, 1, "R1 real ignores paging");

    // R9: back-pressure holds the response
    repeat (4) @(negedge clk);
    set_rdy(1'b0);
    model(16'h0000, 32'h0000_1ABC, 1'b0, 1'b1, 1'b1, est, ea);
    send(16'h0000, 32'h0000_1ABC, 1'b0, 1'b1, 1'b1, 0, "R9 stalled first");
    send(16'h0000, 32'h0000_0042, 1'b0, 1'b1, 1'b0, 0, "R9 stalled second");
    for (int k = 0; k < 3; k++) begin
      checks++;
      if (rsp_valid !== 1'b1 || req_ready !== 1'b0 || rsp_paddr !== ea || rsp_ok !== 1'b1) begin
        fails++;
        $display("FAIL R9 hold: got v=%b rdy=%b addr=%h expected v=1 rdy=0 addr=%h", rsp_valid, req_ready, rsp_paddr, ea);
      end
      @(negedge clk);
    end
    set_rdy(1'b1);
    repeat (6) @(negedge clk);

    checks++;
    if (q_st.size() != 0) begin
      fails++;
      $display("FAIL R9 drain: got %0d pending expected 0", q_st.size());
    end
    summary();
    $finish;
  end

endmodule